// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master driven by a CPU through a small register port. The CPU writes a byte into a transmit holding register, and the byte moves into the shift register as soon as the shifter is free. That lets the CPU queue the next byte while the current one is still going out. Bytes go out most significant bit first. Received bytes go from the shift register into a receive holding register.

Status flags report:

- an empty transmit holder,
- a full receive holder,
- an overrun,
- a mode fault.

A programmable prescaler makes the serial clock. Polarity and phase bits select one of the four usual SPI modes. A single interrupt line combines the flags with their enables.

Clearing the enable bit performs a partial reset. It aborts any transfer, clears the shifter and its edge counter, and releases the serial pins. It keeps the control bits and any pending flags, so software can still service them.

The transfer engine is a three-state machine:

- **OFF**: enable is low.
- **IDLE**: enabled, with nothing to shift.
- **SHIFT**: a byte is on the wire.

Its transitions are:

- **OFF→IDLE** when enable goes high.
- **IDLE→SHIFT** when the transmit holder is full. This loads the shifter.
- **SHIFT→SHIFT** on the last clock edge of a byte while another byte is queued. This reloads the shifter with no gap.
- **SHIFT→IDLE** on the last edge when nothing is queued.
- **Any state→OFF** whenever enable is low.

Top module: `spim_master`

## Requirements
- R1: After system reset the control register (address 0) reads 0x00 and the status register (address 1) reads 0x10. The status bits are: bit 7 receive-full, bit 6 overrun, bit 5 mode-fault, bit 4 transmit-empty, bits 1:0 rate select. Also after reset, `pins_active_o`, `irq_o`, `sck_o` and `mosi_o` are 0. The control bits are: bit 0 enable, bit 1 phase, bit 2 polarity, bit 3 transmit-empty interrupt enable, bit 4 receive-full interrupt enable, bit 5 error interrupt enable, bit 6 mode-fault detect enable. The data register is at address 2.
- R2: A write to the data register while enabled clears transmit-empty. Transmit-empty sets again when the byte moves into the shifter, so a second byte can be queued while the first is shifting.
- R3: Each byte shifts out MSB first over 8 serial clock cycles (16 edges). Queued bytes follow with no gap: every half period, including the one across the byte boundary, has the same length.
- R4: Rate select 0, 1, 2 and 3 gives a serial clock half period of 1, 4, 16 or 64 module clocks. These correspond to division by 2, 8, 32 or 128.
- R5: When idle, the serial clock rests at the polarity bit. With phase 0 the input is sampled on the leading edge and the output changes on the trailing edge. With phase 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R6: A completed byte is copied into the receive holding register and receive-full sets.
- R7: Receive-full clears only when a status read made while it is set is followed by a data read. A data read without that prior status read leaves it set.
- R8: If a byte completes while receive-full is set, overrun sets and the receive holder keeps its earlier byte. The same status-then-data read sequence clears overrun.
- R9: While enable is low, any transfer is aborted, transmit-empty is forced set, data writes are ignored, `sck_o` rests at the polarity level, `mosi_o` and `pins_active_o` are 0. The next transfer after re-enabling sends a full byte.
- R10: Clearing enable leaves the other control bits, the rate select and the pending receive-full, overrun and mode-fault flags unchanged.
- R11: With enable and mode-fault detect both set, a low `ss_n_i` sets mode-fault and clears enable. Mode-fault clears when a status read showing it is followed by a control write.
- R12: `irq_o` is high when any of these holds:
  - transmit-empty is set with its enable,
  - receive-full is set with its enable,
  - overrun or mode-fault is set with the error interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low system reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers clearing sequences) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select sense, low means another master drives the bus |
| pins_active_o | output | 1 | High while the serial pins are under SPI control |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is an overrun in which the earlier byte must survive. The stimulus writes a byte and then queues a second one while the first is still shifting. It then waits without reading until both bytes have completed. That produces a back-to-back stream, where the half period across the byte boundary can be measured, and a second completion while receive-full is still pending.

The partial reset is also hard to reach. It needs a slow rate and a wait long enough that enable is cleared in the middle of a byte, with a receive-full flag left pending from an earlier transfer. The stimulus then re-enables and checks that the next byte arrives whole.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_SHIFT
    } spim_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int RATE_W = 2,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CW = STEP * ((1 << RATE_W) - 1);

    logic [CW-1:0] cnt;
    logic [CW:0]   half_w;
    logic [CW-1:0] lim;

    always_comb begin
        half_w = (CW+1)'(1) << (STEP * int'(rate));
        lim    = CW'(half_w - 1'b1);
    end

    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cpha_i,
    input  logic          tick_i,
    input  logic          tx_full_i,
    input  logic [DW-1:0] tx_byte_i,
    input  logic          miso_i,
    output logic          run_o,
    output logic          take_o,
    output logic          done_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          sck_raw_o,
    output logic          mosi_o
);
    localparam int PW = $clog2(2 * DW);
    localparam logic [PW-1:0] LAST = PW'(2 * DW - 1);

    spim_state_e st, nxt;
    logic [DW-1:0] shreg;
    logic [PW-1:0] ph;
    logic          samp, outb;
    logic          last_edge;

    assign last_edge = (st == ST_SHIFT) && tick_i && (ph == LAST);
    assign run_o     = (st == ST_SHIFT);
    assign rx_byte_o = {shreg[DW-2:0], cpha_i ? miso_i : samp};
    assign mosi_o    = cpha_i ? outb : shreg[DW-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    // next state and strobes
    always_comb begin
        nxt    = st;
        take_o = 1'b0;
        done_o = 1'b0;
        unique case (st)
            ST_OFF:  if (en_i) nxt = ST_IDLE;
            ST_IDLE: if (tx_full_i) begin
                         take_o = 1'b1;
                         nxt    = ST_SHIFT;
                     end
            ST_SHIFT: if (last_edge) begin
                         done_o = 1'b1;
                         if (tx_full_i) take_o = 1'b1;
                         else           nxt    = ST_IDLE;
                     end
            default: nxt = ST_OFF;
        endcase
        if (!en_i) begin
            nxt    = ST_OFF;
            take_o = 1'b0;
            done_o = 1'b0;
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; ph <= '0; sck_raw_o <= 1'b0; samp <= 1'b0; outb <= 1'b0;
        end else if (!en_i) begin
            shreg <= '0; ph <= '0; sck_raw_o <= 1'b0; samp <= 1'b0; outb <= 1'b0;
        end else if (take_o) begin
            shreg     <= tx_byte_i;
            ph        <= '0;
            sck_raw_o <= 1'b0;
        end else if (st == ST_SHIFT && tick_i) begin
            sck_raw_o <= ~sck_raw_o;
            ph        <= ph + 1'b1;
            if (!ph[0]) begin
                samp <= miso_i;
                outb <= shreg[DW-1];
            end else begin
                shreg <= {shreg[DW-2:0], cpha_i ? miso_i : samp};
            end
        end
    end

    p_take_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> tx_full_i);
    p_off_clock_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (sck_raw_o == 1'b0 && ph == '0));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DW     = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ss_n_i,
    input  logic              take_i,
    input  logic              done_i,
    input  logic [DW-1:0]     rx_byte_i,
    output logic              en_o,
    output logic              cpha_o,
    output logic              cpol_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              tx_full_o,
    output logic [DW-1:0]     tx_byte_o,
    output logic              irq_o
);
    logic en, cpha, cpol, txie, rxie, erie, mfen;
    logic [RATE_W-1:0] rate;
    logic tx_full, rx_full, ovr, mf, rx_arm, mf_arm;
    logic [DW-1:0] txbuf, rxbuf;
    logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data, fault, rx_clr, rx_keep;

    assign wr_ctrl = bus_sel && bus_wr && bus_addr == ADDR_CTRL;
    assign wr_stat = bus_sel && bus_wr && bus_addr == ADDR_STAT;
    assign wr_data = bus_sel && bus_wr && bus_addr == ADDR_DATA;
    assign rd_stat = bus_sel && bus_rd && bus_addr == ADDR_STAT;
    assign rd_data = bus_sel && bus_rd && bus_addr == ADDR_DATA;
    assign fault   = en && mfen && !ss_n_i;
    assign rx_clr  = rd_data && rx_arm;
    assign rx_keep = rx_full && !rx_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {mfen, erie, rxie, txie, cpol, cpha, en} <= '0;
            rate <= '0; tx_full <= 1'b0; rx_full <= 1'b0; ovr <= 1'b0;
            mf <= 1'b0; rx_arm <= 1'b0; mf_arm <= 1'b0;
            txbuf <= '0; rxbuf <= '0;
        end else begin
            if (wr_ctrl) {mfen, erie, rxie, txie, cpol, cpha, en} <= bus_wdata[6:0];
            if (wr_stat) rate <= bus_wdata[RATE_W-1:0];
            if (wr_ctrl && mf_arm) mf <= 1'b0;
            if (fault) begin
                en <= 1'b0;
                mf <= 1'b1;
            end
            if (rd_stat)      mf_arm <= mf;
            else if (wr_ctrl) mf_arm <= 1'b0;
            if (rd_stat)      rx_arm <= rx_full | ovr;
            else if (rd_data) rx_arm <= 1'b0;
            if (!en) tx_full <= 1'b0;
            else if (wr_data) begin
                txbuf   <= bus_wdata;
                tx_full <= 1'b1;
            end else if (take_i) tx_full <= 1'b0;
            if (rx_clr) begin
                rx_full <= 1'b0;
                ovr     <= 1'b0;
            end
            if (done_i) begin
                if (rx_keep) ovr <= 1'b1;
                else begin
                    rxbuf   <= rx_byte_i;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata[6:0] = {mfen, erie, rxie, txie, cpol, cpha, en};
            ADDR_STAT: begin
                bus_rdata[7:4]        = {rx_full, ovr, mf, ~tx_full};
                bus_rdata[RATE_W-1:0] = rate;
            end
            ADDR_DATA: bus_rdata = rxbuf;
            default:   bus_rdata = '0;
        endcase
    end

    assign en_o      = en;
    assign cpha_o    = cpha;
    assign cpol_o    = cpol;
    assign rate_o    = rate;
    assign tx_full_o = tx_full;
    assign tx_byte_o = txbuf;
    assign irq_o     = (~tx_full & txie) | (rx_full & rxie) | ((ovr | mf) & erie);

    p_off_txe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tx_full);
    p_ovr_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rx_keep) |=> (ovr && $stable(rxbuf)));
    p_rxfull_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(done_i));
    p_fault_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!en && mf));
endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int DW     = 8,
    parameter int RATE_W = 2,
    parameter int STEP   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sck_o,
    output logic          mosi_o,
    input  logic          miso_i,
    input  logic          ss_n_i,
    output logic          pins_active_o,
    output logic          irq_o
);
    logic en, cpha, cpol, tx_full, take, done, run, tick, sck_raw, mosi_int;
    logic [RATE_W-1:0] rate;
    logic [DW-1:0] tx_byte, rx_byte;

    spim_regs #(.DW(DW), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ss_n_i(ss_n_i), .take_i(take), .done_i(done), .rx_byte_i(rx_byte),
        .en_o(en), .cpha_o(cpha), .cpol_o(cpol), .rate_o(rate),
        .tx_full_o(tx_full), .tx_byte_o(tx_byte), .irq_o(irq_o)
    );

    spim_clkdiv #(.RATE_W(RATE_W), .STEP(STEP)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .rate(rate), .tick(tick)
    );

    spim_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cpha_i(cpha), .tick_i(tick),
        .tx_full_i(tx_full), .tx_byte_i(tx_byte), .miso_i(miso_i),
        .run_o(run), .take_o(take), .done_o(done), .rx_byte_o(rx_byte),
        .sck_raw_o(sck_raw), .mosi_o(mosi_int)
    );

    assign sck_o         = sck_raw ^ cpol;
    assign mosi_o        = en & mosi_int;
    assign pins_active_o = en;
endmodule

// File: tb/sim_spim_master.sv
module sim_spim_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic sck_o, mosi_o, pins_active_o, irq_o;
    logic ss_n_i = 1'b1;
    logic miso_r = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spim_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_r), .ss_n_i(ss_n_i),
        .pins_active_o(pins_active_o), .irq_o(irq_o)
    );

    // slave model
    logic m_cpha = 1'b0, m_cpol = 1'b0, prev_sck = 1'b0;
    logic [15:0] sword = 16'd0, cap = 16'd0;
    int edges = 0, gap = 0, maxgap = 0;

    always @(negedge clk) begin
        if (sck_o !== prev_sck) begin
            if (edges > 0 && gap > maxgap) maxgap = gap;
            gap = 1;
            edges++;
            if ((sck_o ^ m_cpol) == 1'b1) begin
                if (!m_cpha) cap = {cap[14:0], mosi_o};
                else begin
                    miso_r = sword[15];
                    sword  = {sword[14:0], 1'b0};
                end
            end else begin
                if (!m_cpha) begin
                    sword  = {sword[14:0], 1'b0};
                    miso_r = sword[15];
                end else cap = {cap[14:0], mosi_o};
            end
        end else gap++;
        prev_sck = sck_o;
    end

    task automatic preload(input logic cpha, input logic cpol, input logic [15:0] w);
        m_cpha = cpha; m_cpol = cpol; sword = w; cap = 16'd0;
        edges = 0; gap = 0; maxgap = 0;
        miso_r = cpha ? 1'b0 : w[15];
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wait_rx();
        logic [7:0] s;
        s = 8'd0;
        while (!s[7]) rd(2'd1, s);
    endtask

    // cpol, cpha, rate, tx byte, slave byte
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 2'd1, 8'h81, 8'h7E},
        {1'b1, 1'b0, 2'd2, 8'h5A, 8'hC3},
        {1'b1, 1'b1, 2'd3, 8'hF0, 8'h0F},
        {1'b0, 1'b0, 2'd3, 8'h01, 8'h80},
        {1'b1, 1'b1, 2'd0, 8'hFF, 8'h00},
        {1'b0, 1'b1, 2'd2, 8'h6D, 8'hB2},
        {1'b1, 1'b0, 2'd1, 8'h00, 8'hFF}
    };

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 status", d, 8'h10);
        chk("R1 pins", {pins_active_o, irq_o, sck_o, mosi_o}, 4'b0000);

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            logic [19:0] v;
            v = VEC[i];
            wr(2'd0, {5'b00000, v[19], v[18], 1'b1});
            wr(2'd1, {6'd0, v[17:16]});
            preload(v[18], v[19], {v[7:0], 8'h00});
            wr(2'd2, v[15:8]);
            wait_rx();
            chk("R3 R5 mosi byte", cap[7:0], v[15:8]);
            chk("R3 edge count", edges, 16);
            chk("R4 half period", maxgap, 1 << (2 * v[17:16]));
            chk("R5 idle level", sck_o, v[19]);
            rd(2'd2, d); chk("R6 R5 rx byte", d, v[7:0]);
            rd(2'd1, d); chk("R7 cleared", d[7], 1'b0);
        end

        // R2 R3 R8 queued pair with overrun
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h01);
        preload(1'b0, 1'b0, 16'hC31E);
        wr(2'd2, 8'h96);
        rd(2'd1, d); chk("R2 txe cleared by write", d[4], 1'b0);
        repeat (4) @(posedge clk); #1;
        rd(2'd1, d); chk("R2 txe set after move", d[4], 1'b1);
        wr(2'd2, 8'h3B);
        rd(2'd1, d); chk("R2 second byte queued", d[4], 1'b0);
        repeat (200) @(posedge clk); #1;
        chk("R3 pair stream", cap, 16'h963B);
        chk("R3 pair edges", edges, 32);
        chk("R3 no gap", maxgap, 4);
        rd(2'd1, d); chk("R8 overrun status", d, 8'hD1);
        rd(2'd2, d); chk("R8 first byte kept", d, 8'hC3);
        rd(2'd1, d); chk("R8 R7 flags cleared", d, 8'h11);

        // R7 data read alone does not clear
        wr(2'd1, 8'h00);
        preload(1'b0, 1'b0, 16'h5500);
        wr(2'd2, 8'h42);
        repeat (40) @(posedge clk); #1;
        rd(2'd2, d); chk("R7 data without status", d, 8'h55);
        rd(2'd1, d); chk("R7 still full", d[7], 1'b1);
        rd(2'd2, d);
        rd(2'd1, d); chk("R7 clear after sequence", d[7], 1'b0);

        // R9 R10 partial reset mid-transfer with rx pending
        preload(1'b0, 1'b0, 16'h1100);
        wr(2'd2, 8'h22);
        repeat (40) @(posedge clk); #1;
        wr(2'd0, 8'h27);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'hAA);
        repeat (300) @(posedge clk); #1;
        wr(2'd0, 8'h26);
        repeat (2) @(posedge clk); #1;
        chk("R9 pins released", {pins_active_o, sck_o, mosi_o}, 3'b010);
        rd(2'd1, d); chk("R9 R10 status kept", d, 8'h93);
        rd(2'd0, d); chk("R10 ctrl kept", d, 8'h26);
        wr(2'd2, 8'h77);
        rd(2'd1, d); chk("R9 write ignored", d[4], 1'b1);
        rd(2'd2, d); chk("R10 rx byte kept", d, 8'h11);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h27);
        preload(1'b1, 1'b1, 16'h6900);
        wr(2'd2, 8'hC5);
        wait_rx();
        chk("R9 full byte after re-enable", cap[7:0], 8'hC5);
        chk("R9 edges after re-enable", edges, 16);
        rd(2'd2, d); chk("R9 rx after re-enable", d, 8'h69);

        // R11 R12 mode fault
        wr(2'd0, 8'h61);
        ss_n_i = 1'b0;
        repeat (3) @(posedge clk); #1;
        ss_n_i = 1'b1;
        rd(2'd0, d); chk("R11 enable cleared", d, 8'h60);
        rd(2'd1, d); chk("R11 fault flag", d[5], 1'b1);
        chk("R12 error irq", irq_o, 1'b1);
        wr(2'd0, 8'h60);
        rd(2'd1, d); chk("R11 fault cleared", d[5], 1'b0);
        chk("R12 irq dropped", irq_o, 1'b0);

        // R12 transmit-empty and receive-full sources
        wr(2'd0, 8'h08);
        @(posedge clk); #1;
        chk("R12 txe irq", irq_o, 1'b1);
        wr(2'd0, 8'h11);
        chk("R12 no irq before rx", irq_o, 1'b0);
        preload(1'b0, 1'b0, 16'h0F00);
        wr(2'd2, 8'hF0);
        repeat (40) @(posedge clk); #1;
        chk("R12 rx irq", irq_o, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule